// File: doc/BRIEF.md
# Slot Interrupt Merger

This block merges interrupt requests from four plug-in module slots into one host interrupt line. Each slot has two request lines, so there are eight lines in all. A per-slot control byte sets, for each line, whether it is enabled and whether it is edge or level sensitive. A 16-bit status word holds one pending bit per line and one timeout flag per slot. The timeout flags are set by an external detector through a strobe input.

The host reaches the control bytes and the status word through a small register window with 16-bit data. Pending bits are cleared by writing ones to the status word. The module access path can also clear a pending request with an acknowledge strobe, one per line.

Edge-sensitive lines flip the host line for a single clock when they become pending. Level-sensitive lines drive a sticky output. That output stays asserted until no level-sensitive pending bit remains.

Top module: `slot_irq_merger`

## Requirements
- R1: After a synchronous active-low reset, all state is zero: `host_irq` is low and every register offset reads 0x0000.
- R2: Offsets 0x02, 0x04, 0x06 and 0x08 hold the control bytes of slots 0 to 3 (slot = offset/2 - 1). Each byte reads back in bits 7:0, with bits 15:8 zero. Offsets 0x00 and 0x0A read zero and ignore writes. Any other offset reads zero.
- R3: Control bit 6+n enables line n of a slot. A request change on a disabled line leaves its status bit (position slot*2+n at offset 0x0C) unchanged and does not disturb `host_irq`.
- R4: Each line has a request register. It follows its module input whenever that input changes. When the request register changes on an enabled line, the line's status bit takes the new value.
- R5: Control bit 4+n makes line n edge sensitive. A 0-to-1 change of its status bit inverts `host_irq` for exactly one clock. A 1-to-0 change causes no activity on `host_irq`.
- R6: The level output is re-evaluated only when the status bit of a level-sensitive line changes. It is then set when any pending bit of a level-sensitive line is set, and cleared otherwise. Pending bits of edge-sensitive lines never hold it up.
- R7: Writing a one to status bits 7:0 clears the request register of that line. If the line is enabled, its status bit clears as well.
- R8: A `tmo_set` strobe for slot s sets status bit 12+s. Writing a one to that bit clears it. If a strobe and a clear arrive in the same cycle, the strobe wins.
- R9: Status bits 11:8 always read zero, and writing ones to them has no effect.
- R10: An `ack_stb` bit (index slot*2+n) clears the line's request only when its status bit is set and the line is level sensitive. Otherwise the strobe is ignored.
- R11: Status bits and `host_irq` change in the clock cycle right after the input, write or strobe that causes the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mod_req | input | 8 | Module request lines, index slot*2+line, synchronous to clk |
| tmo_set | input | 4 | Per-slot timeout set strobes |
| ack_stb | input | 8 | Per-line acknowledge strobes from the module access path |
| reg_we | input | 1 | Register window write enable |
| reg_addr | input | 8 | Register window byte offset |
| reg_wdata | input | 16 | Register window write data |
| reg_rdata | output | 16 | Register window read data (combinational on reg_addr) |
| host_irq | output | 1 | Shared host interrupt |

## Verification
The assertions assume that `mod_req`, `ack_stb` and `tmo_set` are synchronous to `clk`, and that reset is held across at least one rising edge before any stimulus. The bench drives every input just after a falling edge and holds reset low for several edges. It samples outputs at the following falling edge, so each change lands one register stage after its cause. Each line is tested alone under each of its three configurations, with all other inputs idle, so the expected status word and output level can be computed directly from the line index and mode.

// File: rtl/slot_irq_pkg.sv
// Package: shared constants for the slot interrupt merger.
// Holds register offsets and bit positions that the host software decodes,
// so they are fixed here rather than derived.
package slot_irq_pkg;
    localparam int LINES_PER_SLOT = 2;
    localparam int CTRL_W         = 8;
    localparam int CB_EDGE_BASE   = 4;   // edge-select bits 4..5
    localparam int CB_EN_BASE     = 6;   // enable bits 6..7
    localparam int TMO_BASE       = 12;  // timeout flags 12..15
    localparam int ERR_LO         = 8;
    localparam int ERR_HI         = 11;
    localparam logic [7:0] OFS_REV  = 8'h00;
    localparam logic [7:0] OFS_RST  = 8'h0A;
    localparam logic [7:0] OFS_STAT = 8'h0C;
endpackage

// File: rtl/slot_ctrl_regs.sv
// Module: register window of the slot interrupt merger.
// Holds the per-slot control bytes and the timeout flags. It decodes
// write-one-to-clear requests for the line status bits and muxes read data.
// Assumes single-cycle writes and a combinational read path.
module slot_ctrl_regs
    import slot_irq_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16,
    localparam int NUM_LINES = NUM_SLOTS * LINES_PER_SLOT
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [NUM_LINES-1:0] pend,
    input  logic [NUM_SLOTS-1:0] tmo_set,
    output logic [DATA_W-1:0]    rdata,
    output logic [NUM_LINES-1:0] edge_sel,
    output logic [NUM_LINES-1:0] irq_en,
    output logic [NUM_LINES-1:0] wr_clr
);
    logic [CTRL_W-1:0]    ctrl_q [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] tmo_q;
    logic                 stat_hit;
    logic [NUM_SLOTS-1:0] tmo_clr;

    assign stat_hit = we && (addr == ADDR_W'(OFS_STAT));
    assign wr_clr   = stat_hit ? wdata[NUM_LINES-1:0] : '0;
    assign tmo_clr  = stat_hit ? wdata[TMO_BASE +: NUM_SLOTS] : '0;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        localparam logic [ADDR_W-1:0] SLOT_OFS = ADDR_W'((s + 1) * 2);

        // Control byte storage for one slot.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ctrl_q[s] <= '0;
            else if (we && addr == SLOT_OFS)
                ctrl_q[s] <= wdata[CTRL_W-1:0];
        end

        for (genvar n = 0; n < LINES_PER_SLOT; n++) begin : g_line
            assign edge_sel[s*LINES_PER_SLOT+n] = ctrl_q[s][CB_EDGE_BASE+n];
            assign irq_en[s*LINES_PER_SLOT+n]   = ctrl_q[s][CB_EN_BASE+n];
        end
    end

    // Timeout flags: set strobe has priority over a write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tmo_q <= '0;
        else
            tmo_q <= (tmo_q & ~tmo_clr) | tmo_set;
    end

    // Read mux over the register window.
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFS_STAT)) begin
            rdata[NUM_LINES-1:0]           = pend;
            rdata[TMO_BASE +: NUM_SLOTS]   = tmo_q;
        end
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (addr == ADDR_W'((s + 1) * 2))
                rdata[CTRL_W-1:0] = ctrl_q[s];
        end
    end
endmodule

// File: rtl/slot_line_track.sv
// Module: request and pending state of one interrupt line.
// It mirrors the module request line in a request register that a clear
// can drop. A change of that register updates the pending bit only while
// the line is enabled. Assumes mod_in is synchronous to clk. A module
// change wins over a clear in the same cycle.
module slot_line_track (
    input  logic clk,
    input  logic rst_n,
    input  logic mod_in,
    input  logic en,
    input  logic clr_req,
    output logic pend_q,
    output logic pend_nxt,
    output logic pend_chg,
    output logic pend_rise
);
    logic mod_prev_q;
    logic req_q;
    logic req_nxt;
    logic mod_chg;

    assign mod_chg   = mod_in ^ mod_prev_q;
    assign req_nxt   = mod_chg ? mod_in : (clr_req ? 1'b0 : req_q);
    assign pend_nxt  = (en && (req_nxt != req_q)) ? req_nxt : pend_q;
    assign pend_chg  = pend_nxt ^ pend_q;
    assign pend_rise = pend_nxt & ~pend_q;

    // Line state registers: input history, request mirror, pending bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_prev_q <= 1'b0;
            req_q      <= 1'b0;
            pend_q     <= 1'b0;
        end else begin
            mod_prev_q <= mod_in;
            req_q      <= req_nxt;
            pend_q     <= pend_nxt;
        end
    end
endmodule

// File: rtl/slot_irq_combine.sv
// Module: merges line events into the host interrupt.
// The level output is re-evaluated only when a level-sensitive pending bit
// changes. Edge-sensitive rises produce a one-clock pulse that inverts the
// host line. Both outputs are registered.
module slot_irq_combine #(
    parameter int NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] pend_nxt,
    input  logic [NUM_LINES-1:0] pend_chg,
    input  logic [NUM_LINES-1:0] pend_rise,
    input  logic [NUM_LINES-1:0] edge_sel,
    output logic                 lvl_q,
    output logic                 pulse_q
);
    logic lvl_upd;
    logic lvl_nxt;
    logic pulse_nxt;

    assign lvl_upd   = |(pend_chg & ~edge_sel);
    assign lvl_nxt   = lvl_upd ? |(pend_nxt & ~edge_sel) : lvl_q;
    assign pulse_nxt = |(pend_rise & edge_sel);

    // Sticky level output and single-cycle edge pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q   <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            lvl_q   <= lvl_nxt;
            pulse_q <= pulse_nxt;
        end
    end
endmodule

// File: rtl/slot_irq_merger.sv
// Module: top of the slot interrupt merger.
// Four slots with two request lines each feed a shared host interrupt.
// Assumes every input is synchronous to clk. Acknowledge strobes are
// qualified here: only set, level-sensitive lines accept them.
module slot_irq_merger
    import slot_irq_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16,
    localparam int NUM_LINES = NUM_SLOTS * LINES_PER_SLOT
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] mod_req,
    input  logic [NUM_SLOTS-1:0] tmo_set,
    input  logic [NUM_LINES-1:0] ack_stb,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic                 host_irq
);
    logic [NUM_LINES-1:0] pend_q;
    logic [NUM_LINES-1:0] pend_nxt;
    logic [NUM_LINES-1:0] pend_chg;
    logic [NUM_LINES-1:0] pend_rise;
    logic [NUM_LINES-1:0] edge_sel;
    logic [NUM_LINES-1:0] irq_en;
    logic [NUM_LINES-1:0] wr_clr;
    logic [NUM_LINES-1:0] ack_ok;
    logic                 lvl_q;
    logic                 pulse_q;

    assign ack_ok = ack_stb & pend_q & ~edge_sel;

    slot_ctrl_regs #(
        .NUM_SLOTS(NUM_SLOTS),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .pend    (pend_q),
        .tmo_set (tmo_set),
        .rdata   (reg_rdata),
        .edge_sel(edge_sel),
        .irq_en  (irq_en),
        .wr_clr  (wr_clr)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        slot_line_track u_track (
            .clk      (clk),
            .rst_n    (rst_n),
            .mod_in   (mod_req[i]),
            .en       (irq_en[i]),
            .clr_req  (wr_clr[i] | ack_ok[i]),
            .pend_q   (pend_q[i]),
            .pend_nxt (pend_nxt[i]),
            .pend_chg (pend_chg[i]),
            .pend_rise(pend_rise[i])
        );
    end

    slot_irq_combine #(
        .NUM_LINES(NUM_LINES)
    ) u_comb (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_nxt (pend_nxt),
        .pend_chg (pend_chg),
        .pend_rise(pend_rise),
        .edge_sel (edge_sel),
        .lvl_q    (lvl_q),
        .pulse_q  (pulse_q)
    );

    assign host_irq = lvl_q ^ pulse_q;
endmodule

// File: rtl/slot_irq_merger_chk.sv
// Module: property checker for the slot interrupt merger, bound to the top.
// Assumes inputs are synchronous to clk and reset is held for one edge.
module slot_irq_merger_chk #(
    parameter int NUM_LINES = 8,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 host_irq,
    input logic [NUM_LINES-1:0] pend,
    input logic [NUM_LINES-1:0] edge_sel,
    input logic [NUM_LINES-1:0] irq_en,
    input logic                 lvl,
    input logic                 pulse,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic [DATA_W-1:0]    reg_rdata
);
    // R1: reset drives the host line low on the next cycle.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !host_irq);

    // R4: without a status change the host line holds and no pulse appears.
    a_r4_quiet_without_change: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(pend) |-> ($stable(lvl) && !pulse));

    // R5: a pulse follows only a rise of an edge-sensitive status bit.
    a_r5_pulse_from_edge_rise: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> |(pend & ~$past(pend) & $past(edge_sel)));

    // R9: the error field of the status word reads zero.
    a_r9_error_field_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(8'h0C)) |-> (reg_rdata[11:8] == 4'h0));

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        // R3: a disabled line cannot move its status bit.
        a_r3_disabled_line_holds: assert property (@(posedge clk) disable iff (!rst_n)
            !irq_en[i] |=> $stable(pend[i]));
    end
endmodule

bind slot_irq_merger slot_irq_merger_chk #(
    .NUM_LINES(NUM_LINES),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_irq (host_irq),
    .pend     (pend_q),
    .edge_sel (edge_sel),
    .irq_en   (irq_en),
    .lvl      (lvl_q),
    .pulse    (pulse_q),
    .reg_addr (reg_addr),
    .reg_rdata(reg_rdata)
);

// File: tb/slot_irq_merger_tb_top.sv
`timescale 1ns/1ps
module slot_irq_merger_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  mod_req = '0;
    logic [3:0]  tmo_set = '0;
    logic [7:0]  ack_stb = '0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        host_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    slot_irq_merger dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .mod_req  (mod_req),
        .tmo_set  (tmo_set),
        .ack_stb  (ack_stb),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .host_irq (host_irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  cv;
        int          s;
        int          n;
        int          exp_stat;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state at every even offset
        chk("R1 host_irq", host_irq, 0);
        for (int a = 0; a < 16; a += 2) begin
            rd(8'(a), v);
            chk("R1 reg", v, 0);
        end

        // R2: exhaustive control byte sweep per slot
        for (int sl = 0; sl < 4; sl++) begin
            for (int d = 0; d < 256; d++) begin
                wr(8'((sl + 1) * 2), 16'hA500 | 16'(d));
                rd(8'((sl + 1) * 2), v);
                chk("R2 ctrl readback", v, d);
            end
            wr(8'((sl + 1) * 2), 16'h0000);
        end

        // R2: revision and reset offsets ignore writes and read zero
        wr(8'h02, 16'h005A);
        wr(8'h00, 16'hFFFF);
        wr(8'h0A, 16'hFFFF);
        rd(8'h00, v); chk("R2 revision", v, 0);
        rd(8'h0A, v); chk("R2 reset reg", v, 0);
        rd(8'h0E, v); chk("R2 reserved", v, 0);
        rd(8'h02, v); chk("R2 ctrl untouched", v, 16'h005A);
        wr(8'h02, 16'h0000);

        // Per-line sweep: mode 0 disabled, 1 level, 2 edge
        for (int i = 0; i < 8; i++) begin
            for (int m = 0; m < 3; m++) begin
                s = i / 2;
                n = i % 2;
                cv = '0;
                if (m != 0) cv[6 + n] = 1'b1;
                if (m == 2) cv[4 + n] = 1'b1;
                wr(8'((s + 1) * 2), {8'h00, cv});

                mod_req[i] = 1'b1;
                @(negedge clk);
                exp_stat = (m != 0) ? (1 << i) : 0;
                rd(8'h0C, v);
                chk("R4 R11 R3 status after raise", v, exp_stat);
                chk("R5 R6 R3 host after raise", host_irq, (m != 0) ? 1 : 0);
                @(negedge clk);
                chk("R5 R6 host one cycle later", host_irq, (m == 1) ? 1 : 0);

                ack_stb[i] = 1'b1;
                @(negedge clk);
                ack_stb[i] = 1'b0;
                rd(8'h0C, v);
                chk("R10 status after ack", v, (m == 2) ? (1 << i) : 0);
                chk("R10 host after ack", host_irq, 0);

                wr(8'h0C, 16'(1 << i));
                rd(8'h0C, v);
                chk("R7 status after clear", v, 0);
                chk("R7 R5 no pulse on fall", host_irq, 0);

                mod_req[i] = 1'b0;
                @(negedge clk);
                rd(8'h0C, v);
                chk("R4 status after drop", v, 0);
                chk("R4 host after drop", host_irq, 0);
                wr(8'((s + 1) * 2), 16'h0000);
            end
        end

        // R6: sticky level with two level lines and an edge line
        wr(8'h02, 16'h00C0);
        wr(8'h04, 16'h0050);
        mod_req[1:0] = 2'b11;
        @(negedge clk);
        chk("R6 two level lines", host_irq, 1);
        ack_stb[0] = 1'b1;
        @(negedge clk);
        ack_stb[0] = 1'b0;
        chk("R6 one level line remains", host_irq, 1);
        mod_req[2] = 1'b1;
        @(negedge clk);
        chk("R5 toggle low while level high", host_irq, 0);
        @(negedge clk);
        chk("R5 toggle returns high", host_irq, 1);
        ack_stb[1] = 1'b1;
        @(negedge clk);
        ack_stb[1] = 1'b0;
        chk("R6 edge pending does not hold level", host_irq, 0);
        rd(8'h0C, v);
        chk("R6 only edge bit pending", v, 16'h0004);
        wr(8'h0C, 16'h0004);
        mod_req[2:0] = 3'b000;
        @(negedge clk);
        rd(8'h0C, v);
        chk("R7 all clear", v, 0);
        wr(8'h02, 16'h0000);
        wr(8'h04, 16'h0000);

        // R8 R9: timeout flags and error field
        tmo_set = 4'b1010;
        @(negedge clk);
        tmo_set = '0;
        rd(8'h0C, v);
        chk("R8 timeout set", v, 16'hA000);
        wr(8'h0C, 16'h2F00);
        rd(8'h0C, v);
        chk("R8 R9 partial clear, error field ignored", v, 16'h8000);
        tmo_set = 4'b1000;
        wr(8'h0C, 16'h8000);
        tmo_set = '0;
        rd(8'h0C, v);
        chk("R8 set wins over clear", v, 16'h8000);
        wr(8'h0C, 16'hF000);
        rd(8'h0C, v);
        chk("R8 cleared", v, 0);
        chk("R9 host quiet", host_irq, 0);

        done = 1'b1;
        finish_run();
    end
endmodule